// File: doc/BRIEF.md
# Activation-Network Symbol Sequence Recognizer

This block recognizes a small regular language over a stream of symbol events. The automaton is not held as an encoded state register. Each automaton state is a one-bit activation node, and each labelled transition is a symbol recognizer. A recognizer is enabled only while its source node is active. When the next event carries the recognizer's label, the recognizer fires and hands activation to its target node. Recognition depends only on the order of events. Idle cycles between events have no effect, and events on consecutive cycles are each consumed.

A pulse on `start_i` places activation on the initial node. Every event on `evt_valid_i`/`evt_sym_i` then moves activation along the matching transition. A one-cycle `accept_o` pulse marks each entry into a final state. An event with no outgoing transition from the active state clears all nodes and raises `dead_o`. The block then ignores events until the next `start_i` or reset. `active_o` exposes the one-hot node vector so that it can be compared against a reference automaton.

The transition table is a set of parameters. The default table uses symbol codes a=0, b=1, c=2, d=3 and four states S0 (initial), S1, S2 and S3 (final). Its transitions are S0-a->S1, S0-c->S0, S1-b->S2, S2-a->S1, S2-c->S3 and S3-a->S1.

Top module: `dfa_net_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `active_o` is all zero and `accept_o` and `dead_o` are low.
- R2: On the cycle after `start_i` is sampled high, `active_o` holds only the initial node's bit (bit 0 by default) and `dead_o` is low. `start_i` takes priority over an event presented in the same cycle, and that event is discarded.
- R3: At most one bit of `active_o` is ever set.
- R4: An event whose symbol labels an outgoing transition of the active node moves activation to that transition's target node on the next cycle.
- R5: `accept_o` pulses high for exactly one cycle, on the cycle after an event moves activation into a final state (S3, mask 4'b1000 by default). A final state that is entered again produces another pulse.
- R6: An event with no outgoing transition from the active node clears `active_o` and sets `dead_o` on the next cycle. `dead_o` stays high, and later events are ignored, until `start_i` or `rst`.
- R7: Idle cycles, in which neither `start_i` nor `evt_valid_i` is high, leave `active_o` unchanged and keep `accept_o` low. Events on back-to-back cycles are each consumed.
- R8: Events that arrive before any `start_i` (no node active) change no output.
- R9: With the default parameters, the state after any symbol sequence matches the listed table: S0-a->S1, S0-c->S0, S1-b->S2, S2-a->S1, S2-c->S3, S3-a->S1. Symbol d=3 has no transition from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | External activation of the initial node |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_sym_i | input | SYM_W | Symbol code of the event |
| accept_o | output | 1 | One-cycle pulse on entry into a final state |
| dead_o | output | 1 | No transition matched; network is inactive |
| active_o | output | NUM_STATES | One-hot vector of active nodes |

## Verification
On every cycle the assertions check that at most one node is active and that a start lands on the initial node. They also check that the dead condition empties the network and persists, that accept only accompanies a final node, and that quiet cycles or an empty network leave the nodes untouched. Whether each specific symbol leads to the correct target node can only be shown by the bench scenarios. The same holds for accept pulses on repeated final entries and for the start-over-event priority. The bench compares every cycle against a behavioural transition function.

// File: rtl/dfa_net_pkg.sv
package dfa_net_pkg;
  localparam int unsigned DEF_SYM_W      = 2;
  localparam int unsigned DEF_NUM_STATES = 4;
  localparam int unsigned DEF_NUM_TRANS  = 6;
  localparam int unsigned DEF_INIT       = 0;

  // Example symbol codes
  localparam int unsigned SYM_A = 0;
  localparam int unsigned SYM_B = 1;
  localparam int unsigned SYM_C = 2;
  localparam int unsigned SYM_D = 3;

  typedef enum logic [1:0] {
    REC_WAIT = 2'd0,
    REC_HOLD = 2'd1,
    REC_SEND = 2'd2
  } rec_phase_e;
endpackage

// File: rtl/dfa_act_node.sv
module dfa_act_node (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic set_i,
  output logic act_o
);
  // Two-state activation element: idle or active
  always_ff @(posedge clk) begin
    if (rst)         act_o <= 1'b0;
    else if (load_i) act_o <= set_i;
  end
endmodule

// File: rtl/dfa_sym_recognizer.sv
module dfa_sym_recognizer
  import dfa_net_pkg::*;
#(
  parameter int unsigned SYM_W      = 2,
  parameter int unsigned NUM_STATES = 4,
  parameter int unsigned SRC        = 0,
  parameter int unsigned LABEL      = 0
) (
  input  logic [NUM_STATES-1:0] active_i,
  input  logic                  evt_valid_i,
  input  logic [SYM_W-1:0]      evt_sym_i,
  output logic                  fire_o
);
  localparam logic [SYM_W-1:0] LABEL_CODE = SYM_W'(LABEL);

  rec_phase_e phase;

  // Enabled (hold) while the source node is active; sends on a label match
  always_comb begin
    phase = REC_WAIT;
    if (active_i[SRC]) begin
      phase = REC_HOLD;
      if (evt_valid_i && (evt_sym_i == LABEL_CODE)) phase = REC_SEND;
    end
  end

  assign fire_o = (phase == REC_SEND);
endmodule

// File: rtl/dfa_net_top.sv
module dfa_net_top
  import dfa_net_pkg::*;
#(
  parameter int unsigned SYM_W      = DEF_SYM_W,
  parameter int unsigned NUM_STATES = DEF_NUM_STATES,
  parameter int unsigned NUM_TRANS  = DEF_NUM_TRANS,
  parameter int unsigned INIT_STATE = DEF_INIT,
  parameter logic [NUM_STATES-1:0] FINAL_MASK = NUM_STATES'(8),
  parameter int unsigned TR_SRC [NUM_TRANS] = '{0, 0, 1, 2, 2, 3},
  parameter int unsigned TR_DST [NUM_TRANS] = '{1, 0, 2, 1, 3, 1},
  parameter int unsigned TR_SYM [NUM_TRANS] = '{SYM_A, SYM_C, SYM_B, SYM_A, SYM_C, SYM_A}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  evt_valid_i,
  input  logic [SYM_W-1:0]      evt_sym_i,
  output logic                  accept_o,
  output logic                  dead_o,
  output logic [NUM_STATES-1:0] active_o
);
  logic [NUM_TRANS-1:0] fire;
  logic [NUM_TRANS-1:0] fire_final;
  logic                 any_active;
  logic                 evt_take;
  logic                 node_load;

  assign any_active = |active_o;
  assign evt_take   = evt_valid_i && any_active && !start_i;
  assign node_load  = start_i || evt_take;

  // One recognizer per labelled transition
  for (genvar t = 0; t < NUM_TRANS; t++) begin : g_trans
    dfa_sym_recognizer #(
      .SYM_W      (SYM_W),
      .NUM_STATES (NUM_STATES),
      .SRC        (TR_SRC[t]),
      .LABEL      (TR_SYM[t])
    ) u_rec (
      .active_i    (active_o),
      .evt_valid_i (evt_valid_i),
      .evt_sym_i   (evt_sym_i),
      .fire_o      (fire[t])
    );
    assign fire_final[t] = fire[t] && FINAL_MASK[TR_DST[t]];
  end

  // One activation node per automaton state
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_node
    logic [NUM_TRANS-1:0] hits;
    logic                 set_in;
    for (genvar t = 0; t < NUM_TRANS; t++) begin : g_hit
      assign hits[t] = fire[t] && (TR_DST[t] == s);
    end
    assign set_in = start_i ? (s == INIT_STATE) : (|hits);
    dfa_act_node u_node (
      .clk    (clk),
      .rst    (rst),
      .load_i (node_load),
      .set_i  (set_in),
      .act_o  (active_o[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                   dead_o <= 1'b0;
    else if (start_i)          dead_o <= 1'b0;
    else if (evt_take && !(|fire)) dead_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          accept_o <= 1'b0;
    else if (start_i) accept_o <= FINAL_MASK[INIT_STATE];
    else              accept_o <= evt_take && (|fire_final);
  end
endmodule

// File: rtl/dfa_net_chk.sv
module dfa_net_chk #(
  parameter int unsigned NUM_STATES = 4,
  parameter int unsigned INIT_STATE = 0,
  parameter logic [NUM_STATES-1:0] FINAL_MASK = NUM_STATES'(8)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_i,
  input logic                  evt_valid_i,
  input logic                  accept_o,
  input logic                  dead_o,
  input logic [NUM_STATES-1:0] active_o
);
  localparam logic [NUM_STATES-1:0] INIT_VEC = NUM_STATES'(1) << INIT_STATE;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (active_o == '0 && !accept_o && !dead_o)); // R1
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (active_o == INIT_VEC && !dead_o)); // R2
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_o)); // R3
  AST_ACCEPT_FINAL: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (|(active_o & FINAL_MASK))); // R5
  AST_DEAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dead_o |-> (active_o == '0)); // R6
  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (dead_o && !start_i) |=> dead_o); // R6
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !evt_valid_i) |=> ($stable(active_o) && !accept_o)); // R7
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!start_i && active_o == '0) |=> (active_o == '0)); // R8
endmodule

bind dfa_net_top dfa_net_chk #(
  .NUM_STATES (NUM_STATES),
  .INIT_STATE (INIT_STATE),
  .FINAL_MASK (FINAL_MASK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .evt_valid_i (evt_valid_i),
  .accept_o    (accept_o),
  .dead_o      (dead_o),
  .active_o    (active_o)
);

// File: tb/dfa_net_top_tb_top.sv
module dfa_net_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic [1:0] evt_sym_i = 2'd0;
  logic       accept_o;
  logic       dead_o;
  logic [3:0] active_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference: state -1 means no node active
  int m_state = -1;
  bit m_dead  = 1'b0;
  bit m_acc   = 1'b0;

  always #5 clk = ~clk;

  dfa_net_top dut_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .evt_valid_i (evt_valid_i),
    .evt_sym_i   (evt_sym_i),
    .accept_o    (accept_o),
    .dead_o      (dead_o),
    .active_o    (active_o)
  );

  function automatic int ref_next(int st, int sym);
    case (st)
      0: return (sym == 0) ? 1 : (sym == 2) ? 0 : -1;
      1: return (sym == 1) ? 2 : -1;
      2: return (sym == 0) ? 1 : (sym == 2) ? 3 : -1;
      3: return (sym == 0) ? 1 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] exp_vec();
    return (m_state < 0) ? 4'b0000 : (4'b0001 << m_state);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (active_o !== exp_vec() || accept_o !== m_acc || dead_o !== m_dead) begin
      errors++;
      $display("FAIL %s: active=%b accept=%b dead=%b expected active=%b accept=%b dead=%b",
               tag, active_o, accept_o, dead_o, exp_vec(), m_acc, m_dead);
    end
    checks++;
    if ($countones(active_o) > 1) begin
      errors++;
      $display("FAIL R3: active=%b expected at most one bit", active_o);
    end
  endtask

  // Drive one cycle (from a negedge), update the model, compare at the next negedge
  task automatic cyc(bit s, bit v, int sym, string tag);
    int nx;
    start_i = s; evt_valid_i = v; evt_sym_i = 2'(sym);
    if (s) begin
      m_state = 0; m_dead = 0; m_acc = 0;
    end else if (v && m_state >= 0) begin
      nx = ref_next(m_state, sym);
      if (nx < 0) begin m_state = -1; m_dead = 1; m_acc = 0; end
      else begin m_state = nx; m_acc = (nx == 3); end
    end else begin
      m_acc = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compare("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 after reset");

    // R8: events before start are ignored
    cyc(0, 1, 0, "R8 pre-start a");
    cyc(0, 1, 3, "R8 pre-start d");

    // R2: start
    cyc(1, 0, 0, "R2 start");
    // R4/R5: a b c -> accept
    cyc(0, 1, 0, "R4 S0-a");
    cyc(0, 1, 1, "R4 S1-b");
    cyc(0, 1, 2, "R5 S2-c accept");
    cyc(0, 0, 0, "R5 accept one cycle");
    // R7: idle gaps then resume
    repeat (3) cyc(0, 0, 0, "R7 idle hold");
    cyc(0, 1, 0, "R7 resume S3-a");
    cyc(0, 0, 0, "R7 gap");
    cyc(0, 1, 1, "R7 S1-b after gap");
    cyc(0, 1, 2, "R5 re-entry accept");
    cyc(0, 1, 0, "R7 back-to-back");
    cyc(0, 1, 1, "R7 back-to-back b");
    cyc(0, 1, 2, "R5 back-to-back accept");
    // R6: no transition -> dead
    cyc(0, 1, 3, "R6 d into dead");
    cyc(0, 1, 0, "R6 ignored in dead");
    cyc(0, 0, 0, "R6 dead persists");
    // R2: start wins over same-cycle event
    cyc(1, 1, 0, "R2 start priority");
    cyc(0, 1, 2, "R9 S0-c self loop");
    cyc(0, 1, 1, "R6 S0-b dead");
    // R1: reset mid-run
    cyc(1, 0, 0, "R2 restart");
    cyc(0, 1, 0, "R4 S0-a again");
    rst = 1'b1;
    m_state = -1; m_dead = 0; m_acc = 0;
    @(posedge clk); @(negedge clk);
    compare("R1 mid-run reset");
    rst = 1'b0;

    // R9: random streams against the reference
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0),
          int'($urandom_range(0, 3)), "R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule